// File: doc/BRIEF.md
# Configurable-Frame UART Transceiver

A full-duplex asynchronous serial port with no clock line. The transmitter serializes one character per valid/ready handshake. The receiver locks onto each character from the falling edge of its start bit and then samples every later bit at its centre. Both directions use a 16x oversampling tick. The tick is derived from a run-time divisor, so one bit lasts 16 × (divisor + 1) system clocks.

The character format is set at run time through three inputs: a data length of 5 to 9 bits, an optional even or odd parity bit, and a stop field of one, one and a half or two bit times. The transmitter latches the format when it accepts a character, and the receiver latches it when it confirms a start bit. Optional clear-to-send/request-to-send flow control holds back new transmissions and tells the far end when the one-character receive buffer is occupied.

Top module: `uart_frame_xcvr`

## Requirements
- R1: After a handshake cycle (tx_valid_i and tx_ready_o both high), tx_o is low from the next cycle as the start bit, and tx_ready_o stays low until the character ends.
- R2: Data bits follow the start bit, least significant bit first, and their count is data_len_i (5 to 9; smaller values act as 5 and larger ones as 9). Received data is right-aligned on rx_data_o, with the unused upper bits at zero.
- R3: par_mode_i selects the parity: 2'b01 gives even, 2'b10 gives odd, and 2'b00 or 2'b11 gives none. When parity is enabled, one parity bit follows the data bits, chosen so that the count of ones across the data and parity bits is even (even mode) or odd (odd mode).
- R4: The stop field drives tx_o high for 16, 24 or 32 ticks when stop_sel_i is 2'b00, 2'b01 or 2'b10/2'b11. tx_ready_o returns high only when that field ends. While tx_ready_o is high, tx_o is high.
- R5: Each bit lasts 16 oversampling ticks, and one tick lasts div_i + 1 clock cycles.
- R6: When flow_en_i is high and cts_i is low, tx_ready_o is low, so no new character starts. tx_ready_o is high once cts_i returns high and the transmitter is idle.
- R7: A low level on rx_i that has ended by the midpoint of the start bit is treated as a glitch and produces no character.
- R8: A completed character sets rx_valid_o. rx_valid_o holds, with its data and flags, until a cycle with rx_ready_i high clears it.
- R9: rx_par_err_o is set with a character whose parity was enabled and did not match the selected mode.
- R10: rx_frm_err_o is set with a character whose first stop bit read low at its centre.
- R11: When flow_en_i is high, rts_o is low while rx_valid_o is high and high otherwise. When flow_en_i is low, rts_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Oversampling tick divisor: one tick every div_i+1 cycles |
| data_len_i | input | 4 | Data bits per character, 5..9 |
| par_mode_i | input | 2 | Parity mode: 01 even, 10 odd, 00/11 none |
| stop_sel_i | input | 2 | Stop length: 00 one, 01 one and a half, 1x two |
| flow_en_i | input | 1 | Enables CTS gating and RTS signalling |
| cts_i | input | 1 | Far end ready to accept data (high = clear) |
| rts_o | output | 1 | Receive buffer free (high = send allowed) |
| tx_data_i | input | 9 | Character to send, right-aligned |
| tx_valid_i | input | 1 | Transmit request |
| tx_ready_o | output | 1 | Transmitter accepts a character this cycle |
| tx_o | output | 1 | Serial output line, idles high |
| rx_i | input | 1 | Serial input line |
| rx_data_o | output | 9 | Received character, right-aligned |
| rx_valid_o | output | 1 | Receive buffer holds a character |
| rx_ready_i | input | 1 | Consumer reads the buffer |
| rx_par_err_o | output | 1 | Parity mismatch on the buffered character |
| rx_frm_err_o | output | 1 | Low stop bit on the buffered character |

## Verification
A transmitted character and a received character can be in flight during the same cycles, because both halves share the format inputs and the oversampling tick. The bench starts a send and a receive together under one format and decodes tx_o and rx_data_o independently, so that any crosstalk through the shared tick or the format latch shows up as a wrong bit. The sweeps cover every combination of data length, parity mode and stop length in both directions. The bench places its samples at bit centres, which it computes from the divisor.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int MAX_LEN = 9;
  localparam int MIN_LEN = 5;
  localparam int OSR     = 16;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} fsm_e;

  function automatic logic [3:0] clamp_len(input logic [3:0] l);
    if (l < 4'(MIN_LEN)) return 4'(MIN_LEN);
    if (l > 4'(MAX_LEN)) return 4'(MAX_LEN);
    return l;
  endfunction

  function automatic logic [MAX_LEN-1:0] len_mask(input logic [3:0] l);
    logic [MAX_LEN-1:0] one;
    one = MAX_LEN'(1);
    return (one << l) - one;
  endfunction

  function automatic logic par_on(input logic [1:0] m);
    return m == 2'b01 || m == 2'b10;
  endfunction

  // ticks in the stop field: 2, 3 or 4 half bits
  function automatic logic [5:0] stop_ticks(input logic [1:0] s);
    case (s)
      2'b00:   return 6'(OSR);
      2'b01:   return 6'(OSR + OSR/2);
      default: return 6'(2*OSR);
    endcase
  endfunction
endpackage

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_frame_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [3:0]         len_i,
  input  logic [1:0]         par_i,
  input  logic [1:0]         stop_i,
  input  logic               can_start_i,
  input  logic [MAX_LEN-1:0] data_i,
  input  logic               valid_i,
  output logic               ready_o,
  output logic               tx_o
);
  localparam logic [5:0] LAST = 6'(OSR - 1);

  fsm_e               state_q;
  logic [MAX_LEN-1:0] sh_q;
  logic [3:0]         left_q;
  logic [5:0]         tcnt_q;
  logic [5:0]         stop_q;
  logic               par_en_q, par_q;
  logic [3:0]         ln;
  logic [MAX_LEN-1:0] dm;

  assign ln      = clamp_len(len_i);
  assign dm      = data_i & len_mask(ln);
  assign ready_o = (state_q == ST_IDLE) && can_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tx_o     <= 1'b1;
      sh_q     <= '0;
      left_q   <= '0;
      tcnt_q   <= '0;
      stop_q   <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (valid_i && ready_o) begin
          sh_q     <= dm;
          left_q   <= ln - 4'd1;
          par_en_q <= par_on(par_i);
          par_q    <= (^dm) ^ (par_i == 2'b10);
          stop_q   <= stop_ticks(stop_i);
          tcnt_q   <= '0;
          tx_o     <= 1'b0;
          state_q  <= ST_START;
        end
        ST_START: if (tick_i) begin
          if (tcnt_q == LAST) begin
            tcnt_q  <= '0;
            tx_o    <= sh_q[0];
            sh_q    <= sh_q >> 1;
            state_q <= ST_DATA;
          end else tcnt_q <= tcnt_q + 6'd1;
        end
        ST_DATA: if (tick_i) begin
          if (tcnt_q == LAST) begin
            tcnt_q <= '0;
            if (left_q == '0) begin
              tx_o    <= par_en_q ? par_q : 1'b1;
              state_q <= par_en_q ? ST_PAR : ST_STOP;
            end else begin
              tx_o   <= sh_q[0];
              sh_q   <= sh_q >> 1;
              left_q <= left_q - 4'd1;
            end
          end else tcnt_q <= tcnt_q + 6'd1;
        end
        ST_PAR: if (tick_i) begin
          if (tcnt_q == LAST) begin
            tcnt_q  <= '0;
            tx_o    <= 1'b1;
            state_q <= ST_STOP;
          end else tcnt_q <= tcnt_q + 6'd1;
        end
        ST_STOP: if (tick_i) begin
          if (tcnt_q == stop_q - 6'd1) begin
            tcnt_q  <= '0;
            state_q <= ST_IDLE;
          end else tcnt_q <= tcnt_q + 6'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_frame_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [3:0]         len_i,
  input  logic [1:0]         par_i,
  input  logic               rx_i,
  input  logic               ready_i,
  output logic [MAX_LEN-1:0] data_o,
  output logic               valid_o,
  output logic               par_err_o,
  output logic               frm_err_o
);
  localparam logic [3:0] MID  = 4'(OSR/2 - 1);
  localparam logic [3:0] LAST = 4'(OSR - 1);

  logic               s1_q, s2_q, prev_q;
  fsm_e               state_q;
  logic [3:0]         tcnt_q, got_q, len_q;
  logic [MAX_LEN-1:0] sh_q, dat;
  logic               par_en_q, odd_q, pbit_q;

  assign dat = sh_q >> (4'(MAX_LEN) - len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1; s2_q <= 1'b1; prev_q <= 1'b1;
    end else begin
      s1_q <= rx_i; s2_q <= s1_q; prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tcnt_q    <= '0;
      got_q     <= '0;
      len_q     <= 4'(MIN_LEN);
      sh_q      <= '0;
      par_en_q  <= 1'b0;
      odd_q     <= 1'b0;
      pbit_q    <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (prev_q && !s2_q) begin
          tcnt_q   <= '0;
          len_q    <= clamp_len(len_i);
          par_en_q <= par_on(par_i);
          odd_q    <= (par_i == 2'b10);
          state_q  <= ST_START;
        end
        ST_START: if (tick_i) begin
          if (tcnt_q == MID) begin
            tcnt_q  <= '0;
            got_q   <= '0;
            state_q <= s2_q ? ST_IDLE : ST_DATA;  // high at mid-bit: glitch
          end else tcnt_q <= tcnt_q + 4'd1;
        end
        ST_DATA: if (tick_i) begin
          if (tcnt_q == LAST) begin
            tcnt_q <= '0;
            sh_q   <= {s2_q, sh_q[MAX_LEN-1:1]};
            got_q  <= got_q + 4'd1;
            if (got_q == len_q - 4'd1) state_q <= par_en_q ? ST_PAR : ST_STOP;
          end else tcnt_q <= tcnt_q + 4'd1;
        end
        ST_PAR: if (tick_i) begin
          if (tcnt_q == LAST) begin
            tcnt_q  <= '0;
            pbit_q  <= s2_q;
            state_q <= ST_STOP;
          end else tcnt_q <= tcnt_q + 4'd1;
        end
        ST_STOP: if (tick_i) begin
          if (tcnt_q == LAST) begin
            tcnt_q    <= '0;
            data_o    <= dat;
            valid_o   <= 1'b1;
            frm_err_o <= !s2_q;
            par_err_o <= par_en_q && (((^dat) ^ pbit_q) != odd_q);
            state_q   <= ST_IDLE;
          end else tcnt_q <= tcnt_q + 4'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_xcvr.sv
module uart_frame_xcvr
  import uart_frame_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [3:0]         data_len_i,
  input  logic [1:0]         par_mode_i,
  input  logic [1:0]         stop_sel_i,
  input  logic               flow_en_i,
  input  logic               cts_i,
  output logic               rts_o,
  input  logic [MAX_LEN-1:0] tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  output logic               tx_o,
  input  logic               rx_i,
  output logic [MAX_LEN-1:0] rx_data_o,
  output logic               rx_valid_o,
  input  logic               rx_ready_i,
  output logic               rx_par_err_o,
  output logic               rx_frm_err_o
);
  logic tick;

  uart_os_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  uart_tx_core u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .len_i(data_len_i), .par_i(par_mode_i), .stop_i(stop_sel_i),
    .can_start_i(!flow_en_i || cts_i),
    .data_i(tx_data_i), .valid_i(tx_valid_i), .ready_o(tx_ready_o), .tx_o(tx_o)
  );

  uart_rx_core u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .len_i(data_len_i), .par_i(par_mode_i), .rx_i(rx_i), .ready_i(rx_ready_i),
    .data_o(rx_data_o), .valid_o(rx_valid_o),
    .par_err_o(rx_par_err_o), .frm_err_o(rx_frm_err_o)
  );

  assign rts_o = !(flow_en_i && rx_valid_o);
endmodule

// File: rtl/uart_frame_chk.sv
module uart_frame_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic flow_en_i,
  input logic cts_i,
  input logic rts_o,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic tx_o,
  input logic rx_valid_o,
  input logic rx_ready_i
);
  // R1
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> (!tx_o && !tx_ready_o));
  // R4
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> tx_o);
  // R6
  cts_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_en_i && !cts_i) |-> !tx_ready_o);
  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o);
  // R11
  rts_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_en_i && rx_valid_o) |-> !rts_o);
  // R11
  rts_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flow_en_i |-> rts_o);
endmodule

bind uart_frame_xcvr uart_frame_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flow_en_i(flow_en_i), .cts_i(cts_i),
  .rts_o(rts_o), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .tx_o(tx_o),
  .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i)
);

// File: tb/sim_uart_frame_xcvr.sv
module sim_uart_frame_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] div = 16'(DIV);
  logic [3:0] dlen = 4'd8;
  logic [1:0] pmode = 2'b00, ssel = 2'b00;
  logic flow_en = 1'b0, cts = 1'b1, rts;
  logic [8:0] tx_data = '0;
  logic tx_valid = 1'b0, tx_ready, tx_line;
  logic rx_line = 1'b1, rx_ready = 1'b0;
  logic [8:0] rx_data;
  logic rx_valid, rx_perr, rx_ferr;
  int total = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_xcvr #(.DIV_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .data_len_i(dlen),
    .par_mode_i(pmode), .stop_sel_i(ssel), .flow_en_i(flow_en), .cts_i(cts),
    .rts_o(rts), .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_o(tx_line), .rx_i(rx_line), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .rx_par_err_o(rx_perr), .rx_frm_err_o(rx_ferr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pbit(input int d, input int len, input int pm);
    int ones = $countones(d & ((1 << len) - 1));
    return (pm == 2) ? 1 - (ones % 2) : ones % 2;
  endfunction

  function automatic int halves(input int ss);
    return (ss == 0) ? 2 : (ss == 1) ? 3 : 4;
  endfunction

  task automatic tx_char(input int d, input int len, input int pm, input int ss);
    int n = 0, p = (pm == 1 || pm == 2), k0, t;
    @(negedge clk);
    dlen = 4'(len); pmode = 2'(pm); ssel = 2'(ss);
    tx_data = 9'(d); tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
    chk(!tx_line && !tx_ready, "R1 start", int'(tx_line), 0);
    repeat (BIT/2) @(negedge clk); n = BIT/2;
    chk(!tx_line, "R5 start mid", int'(tx_line), 0);
    for (int k = 1; k <= len; k++) begin
      repeat (BIT*k + BIT/2 - n) @(negedge clk); n = BIT*k + BIT/2;
      chk(tx_line == d[k-1], "R2 data bit", int'(tx_line), (d >> (k-1)) & 1);
    end
    if (p) begin
      repeat (BIT*(len+1) + BIT/2 - n) @(negedge clk); n = BIT*(len+1) + BIT/2;
      chk(int'(tx_line) == pbit(d, len, pm), "R3 parity", int'(tx_line), pbit(d, len, pm));
    end
    k0 = 1 + len + p;
    repeat (BIT*k0 + BIT/4 - n) @(negedge clk); n = BIT*k0 + BIT/4;
    chk(tx_line, "R4 stop high", int'(tx_line), 1);
    t = BIT*k0 + halves(ss)*BIT/2;
    repeat (t - 3 - n) @(negedge clk); n = t - 3;
    chk(!tx_ready && tx_line, "R4 stop length busy", int'(tx_ready), 0);
    repeat (4) @(negedge clk);
    chk(tx_ready, "R4 ready after stop", int'(tx_ready), 1);
  endtask

  task automatic rx_char(input int d, input int len, input int pm, input int ss,
                         input bit bad_par, input bit bad_stop);
    int p = (pm == 1 || pm == 2);
    @(negedge clk);
    dlen = 4'(len); pmode = 2'(pm); ssel = 2'(ss);
    rx_line = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rx_line = d[i]; repeat (BIT) @(negedge clk);
    end
    if (p) begin
      rx_line = 1'(pbit(d, len, pm)) ^ bad_par; repeat (BIT) @(negedge clk);
    end
    rx_line = !bad_stop; repeat (BIT) @(negedge clk);
    rx_line = 1'b1; repeat (BIT) @(negedge clk);
    chk(rx_valid, "R8 valid", int'(rx_valid), 1);
    chk(int'(rx_data) == (d & ((1 << len) - 1)), "R2 rx data", int'(rx_data), d & ((1 << len) - 1));
    chk(rx_perr == (bad_par && p), "R9 parity flag", int'(rx_perr), int'(bad_par && p));
    chk(rx_ferr == bad_stop, "R10 frame flag", int'(rx_ferr), int'(bad_stop));
    chk(rts == !flow_en, "R11 rts busy", int'(rts), int'(!flow_en));
    repeat (40) @(negedge clk);
    chk(rx_valid, "R8 hold", int'(rx_valid), 1);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    chk(!rx_valid, "R8 cleared", int'(rx_valid), 0);
    chk(rts, "R11 rts free", int'(rts), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", cyc, WDOG);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_line && tx_ready && !rx_valid && rts, "R4 reset idle", int'(tx_line), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int len = 5; len <= 9; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int ss = 0; ss < 3; ss++)
          tx_char((len*73 + pm*29 + ss*11 + 85) & 511, len, pm, ss);

    for (int len = 5; len <= 9; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int ss = 0; ss < 3; ss++)
          rx_char((len*41 + pm*97 + ss*13 + 170) & 511, len, pm, ss, 1'b0, 1'b0);

    // R9 wrong parity bit, both modes
    for (int len = 5; len <= 9; len++) begin
      rx_char(len*59 & 511, len, 1, 0, 1'b1, 1'b0);
      rx_char(len*61 & 511, len, 2, 0, 1'b1, 1'b0);
    end
    // R10 low stop bit
    rx_char(9'h0A5, 8, 0, 0, 1'b0, 1'b1);
    rx_char(9'h15A, 9, 1, 2, 1'b0, 1'b1);

    // R7 short low pulse on rx
    @(negedge clk); rx_line = 1'b0;
    repeat (6) @(negedge clk); rx_line = 1'b1;
    repeat (3*BIT) @(negedge clk);
    chk(!rx_valid, "R7 glitch dropped", int'(rx_valid), 0);
    rx_char(9'h033, 7, 2, 1, 1'b0, 1'b0);

    // R6 / R11 flow control
    @(negedge clk); flow_en = 1'b1; cts = 1'b0; tx_data = 9'h0C3; tx_valid = 1'b1;
    #1 chk(!tx_ready, "R6 cts gate", int'(tx_ready), 0);
    repeat (3*BIT) @(negedge clk);
    chk(!tx_ready && tx_line, "R6 no start", int'(tx_line), 1);
    tx_valid = 1'b0; cts = 1'b1;
    #1 chk(tx_ready, "R6 cts release", int'(tx_ready), 1);
    tx_char(9'h0C3, 8, 1, 0);
    rx_char(9'h05C, 8, 2, 2, 1'b0, 1'b0);
    flow_en = 1'b0;

    // full duplex: send and receive in the same cycles
    for (int len = 5; len <= 9; len += 2)
      fork
        tx_char((len*101) & 511, len, 1, 1);
        rx_char((len*23 + 7) & 511, len, 1, 1, 1'b0, 1'b0);
      join

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule